// File: doc/BRIEF.md
# AHB-Lite Single-Transfer Master

This block turns a simple command stream into AHB-Lite single transfers. A client presents one command at a time: an address, write data, a read/write flag, a size code and a lane-formatting flag. It is held until the block raises `cmd_ready`. The master drives the address phase, then the data phase. Once the slave finishes, it returns a one-cycle response with a status code and, for reads, the sampled read data.

The `pipe_mode` input selects how transfers are scheduled. In pipelined mode the address phase of the next command overlaps the data phase of the current one. In non-pipelined mode a new address phase starts only after the previous data phase has ended.

When a slave answers with an error, the master withdraws the queued address phase during the second error cycle and issues it again one cycle later. A data phase whose wait states run past a parameterised limit is closed with a timeout status. Write data narrower than the bus can be moved into its little-endian byte lanes.

Top module: `ahbm_master`

## Requirements
- R1: While `hresetn` is low, `htrans` is IDLE (2'b00), `cmd_ready` is 0 and `rsp_valid` is 0.
- R2: With `pipe_mode` = 0, an accepted command appears on the bus as NONSEQ (2'b10) in the cycle after acceptance. `cmd_ready` stays 0 during that address phase, and `htrans` returns to IDLE during the data phase that follows.
- R3: With `pipe_mode` = 1, a command offered during an address phase that completes is accepted at the same edge. Its address phase then overlaps the previous data phase, for both write-then-read and read-then-write pairs.
- R4: While `hready` is low with `hresp` low, a NONSEQ address phase (`haddr`, `htrans`, `hwrite`, `hsize`) is held unchanged. `hwdata` is held unchanged whenever `hready` is low.
- R5: On an error response, the first cycle has `hready` low and `hresp` high, and the second has both high. The master drives `htrans` IDLE in the second cycle, and the erroring command completes with status 2'b01.
- R6: An address phase cancelled by an error is re-issued as NONSEQ with the same address in the cycle right after the second error cycle, and then completes normally.
- R7: If `hready` stays low for TIMEOUT_CYC consecutive data-phase cycles, the command completes with status 2'b10 at the edge that ends the last of those cycles, and `rsp_rdata` reads 0.
- R8: With `cmd_fmt` = 1, write data is masked to the transfer size and shifted left by 8 times the byte offset. The offset is the low address bits rounded down to the transfer size, and byte 0 maps to `hwdata[7:0]`.
- R9: With `cmd_fmt` = 0, `cmd_wdata` reaches `hwdata` unchanged regardless of address and size.
- R10: `cmd_size` gives log2 of the byte count (0 byte, 1 halfword, 2 word) and is driven on `hsize`. Any code above the bus width's log2 is issued as the full bus width.
- R11: Every command produces exactly one `rsp_valid` pulse of one cycle, in the cycle after its data phase ends. Status 2'b00 means OK. `rsp_rdata` carries `hrdata` for reads and 0 for writes, and status 2'b11 never occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| hclk | input | 1 | Bus clock |
| hresetn | input | 1 | Asynchronous active-low reset |
| pipe_mode | input | 1 | 1 = overlap next address phase with current data phase |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command accepted at this edge when valid |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | ADDR_W | Transfer address |
| cmd_wdata | input | DATA_W | Write data (unformatted) |
| cmd_size | input | 3 | log2 of byte count |
| cmd_fmt | input | 1 | 1 = place write data in active byte lanes |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_status | output | 2 | 00 OK, 01 error, 10 timeout |
| rsp_rdata | output | DATA_W | Read data of the completed command |
| haddr | output | ADDR_W | Bus address |
| htrans | output | 2 | Transfer type (IDLE or NONSEQ) |
| hwrite | output | 1 | Bus direction |
| hsize | output | 3 | Bus transfer size |
| hwdata | output | DATA_W | Bus write data |
| hrdata | input | DATA_W | Bus read data |
| hready | input | 1 | Slave ready / transfer done |
| hresp | input | 1 | Slave error response |

## Verification
The assertions assume the slave obeys the two-cycle error shape. An error cycle with `hready` low is always followed by one with `hready` and `hresp` both high, and `hresp` is otherwise low. They also assume `pipe_mode` changes only while no transfer is in flight. The bench's slave side drives `hready` and `hresp` only in those legal patterns: wait states with `hresp` low, and one properly formed error pair. It also changes `pipe_mode` only between command groups, once every response has come back.

// File: rtl/ahbm_pkg.sv
package ahbm_pkg;

    typedef enum logic [1:0] {
        HT_IDLE   = 2'b00,
        HT_BUSY   = 2'b01,
        HT_NONSEQ = 2'b10,
        HT_SEQ    = 2'b11
    } htrans_e;

    localparam logic [1:0] RSP_OK  = 2'b00;
    localparam logic [1:0] RSP_ERR = 2'b01;
    localparam logic [1:0] RSP_TMO = 2'b10;

    localparam int HSIZE_W = 3;

endpackage

// File: rtl/ahbm_lane_fmt.sv
module ahbm_lane_fmt #(
    parameter int DATA_W = 32
) (
    input  logic                       fmt_en,
    input  logic [2:0]                 size,
    input  logic [$clog2(DATA_W/8)-1:0] addr_lo,
    input  logic [DATA_W-1:0]          wdata,
    output logic [DATA_W-1:0]          wdata_out
);
    localparam int LANE_W = $clog2(DATA_W/8);

    logic [DATA_W-1:0] keep;
    logic [LANE_W-1:0] off;
    logic [DATA_W-1:0] placed;

    always_comb begin
        // bytes above the transfer size are dropped before shifting
        if (int'(size) >= LANE_W) begin
            keep = '1;
        end else begin
            keep = ~({DATA_W{1'b1}} << (32'd8 << size));
        end
        // lane offset: low address bits rounded down to the transfer size
        off       = addr_lo & LANE_W'(~((32'd1 << size) - 32'd1));
        placed    = (wdata & keep) << {off, 3'b000};
        wdata_out = fmt_en ? placed : wdata;
    end

endmodule

// File: rtl/ahbm_wait_timer.sv
module ahbm_wait_timer #(
    parameter int LIMIT = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    output logic expired
);
    localparam int CNT_W = $clog2(LIMIT + 1);

    logic [CNT_W-1:0] cnt_q, cnt_d;

    assign expired = active && (cnt_q == CNT_W'(LIMIT - 1));

    always_comb begin
        cnt_d = (active && !expired) ? cnt_q + 1'b1 : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // a stalled cycle that does not expire must leave a nonzero count behind
    assert_count_runs_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !expired) |=> (cnt_q != '0));

    // a quiet cycle always restarts the count
    assert_count_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> (cnt_q == '0));

endmodule

// File: rtl/ahbm_master.sv
module ahbm_master
    import ahbm_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int DATA_W      = 32,
    parameter int TIMEOUT_CYC = 100
) (
    input  logic              hclk,
    input  logic              hresetn,
    input  logic              pipe_mode,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic              cmd_write,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [DATA_W-1:0] cmd_wdata,
    input  logic [2:0]        cmd_size,
    input  logic              cmd_fmt,
    output logic              rsp_valid,
    output logic [1:0]        rsp_status,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] haddr,
    output logic [1:0]        htrans,
    output logic              hwrite,
    output logic [2:0]        hsize,
    output logic [DATA_W-1:0] hwdata,
    input  logic [DATA_W-1:0] hrdata,
    input  logic              hready,
    input  logic              hresp
);
    localparam int LANE_W = $clog2(DATA_W / 8);

    typedef struct packed {
        logic              ap_valid;
        logic [ADDR_W-1:0] ap_addr;
        logic              ap_write;
        logic [2:0]        ap_size;
        logic [DATA_W-1:0] ap_wdata;
        logic              cancel;
        logic              dp_valid;
        logic              dp_write;
        logic [DATA_W-1:0] wdata_out;
        logic              rsp_valid;
        logic [1:0]        rsp_status;
        logic [DATA_W-1:0] rsp_rdata;
    } mst_state_t;

    mst_state_t s_q, s_d;

    logic [2:0]        size_eff;
    logic [DATA_W-1:0] lane_wdata;
    logic              tmo_hit;
    logic              ap_adv;

    assign size_eff = (cmd_size > 3'(LANE_W)) ? 3'(LANE_W) : cmd_size;

    ahbm_lane_fmt #(.DATA_W(DATA_W)) u_lane_fmt (
        .fmt_en    (cmd_fmt),
        .size      (size_eff),
        .addr_lo   (cmd_addr[LANE_W-1:0]),
        .wdata     (cmd_wdata),
        .wdata_out (lane_wdata)
    );

    ahbm_wait_timer #(.LIMIT(TIMEOUT_CYC)) u_wait_timer (
        .clk     (hclk),
        .rst_n   (hresetn),
        .active  (s_q.dp_valid && !hready),
        .expired (tmo_hit)
    );

    assign ap_adv = s_q.ap_valid && !s_q.cancel && hready;

    always_comb begin
        if (!hresetn)       cmd_ready = 1'b0;
        else if (pipe_mode) cmd_ready = !s_q.ap_valid || (hready && !s_q.cancel);
        else                cmd_ready = !s_q.ap_valid && (!s_q.dp_valid || hready);
    end

    always_comb begin
        s_d           = s_q;
        s_d.rsp_valid = 1'b0;

        // data phase completion: normal end, error end, or timeout
        if (s_q.dp_valid && hready) begin
            s_d.rsp_valid  = 1'b1;
            s_d.rsp_status = hresp ? RSP_ERR : RSP_OK;
            s_d.rsp_rdata  = s_q.dp_write ? '0 : hrdata;
            s_d.dp_valid   = 1'b0;
            s_d.cancel     = 1'b0;
        end else if (tmo_hit) begin
            s_d.rsp_valid  = 1'b1;
            s_d.rsp_status = RSP_TMO;
            s_d.rsp_rdata  = '0;
            s_d.dp_valid   = 1'b0;
            s_d.cancel     = 1'b0;
        end else if (s_q.dp_valid && hresp) begin
            // first error cycle: withdraw the queued address phase next cycle
            s_d.cancel = 1'b1;
        end

        // address phase hands over to data phase
        if (ap_adv) begin
            s_d.ap_valid = 1'b0;
            s_d.dp_valid = 1'b1;
            s_d.dp_write = s_q.ap_write;
            if (s_q.ap_write) s_d.wdata_out = s_q.ap_wdata;
        end

        // new command into the address phase
        if (cmd_valid && cmd_ready) begin
            s_d.ap_valid = 1'b1;
            s_d.ap_addr  = cmd_addr;
            s_d.ap_write = cmd_write;
            s_d.ap_size  = size_eff;
            s_d.ap_wdata = lane_wdata;
        end
    end

    always_ff @(posedge hclk or negedge hresetn) begin
        if (!hresetn) s_q <= '0;
        else          s_q <= s_d;
    end

    assign htrans     = (s_q.ap_valid && !s_q.cancel) ? HT_NONSEQ : HT_IDLE;
    assign haddr      = s_q.ap_addr;
    assign hwrite     = s_q.ap_write;
    assign hsize      = s_q.ap_size;
    assign hwdata     = s_q.wdata_out;
    assign rsp_valid  = s_q.rsp_valid;
    assign rsp_status = s_q.rsp_status;
    assign rsp_rdata  = s_q.rsp_rdata;

    assert_reset_quiet_R1: assert property (@(posedge hclk)
        !hresetn |-> (!cmd_ready && htrans == HT_IDLE && !rsp_valid));

    assert_nonpipe_gap_R2: assert property (@(posedge hclk) disable iff (!hresetn)
        (!pipe_mode && htrans == HT_NONSEQ && hready) |=> (htrans == HT_IDLE));

    assert_addr_hold_R4: assert property (@(posedge hclk) disable iff (!hresetn)
        (!hready && !hresp && htrans == HT_NONSEQ) |=>
        ($stable(haddr) && $stable(htrans) && $stable(hwrite) && $stable(hsize)));

    assert_wdata_hold_R4: assert property (@(posedge hclk) disable iff (!hresetn)
        !hready |=> $stable(hwdata));

    assert_err_idle_R5: assert property (@(posedge hclk) disable iff (!hresetn)
        (hresp && !hready) |=> (htrans == HT_IDLE));

    assert_err_retry_R6: assert property (@(posedge hclk) disable iff (!hresetn)
        (hresp && !hready && htrans == HT_NONSEQ) |=> ##1
        (htrans == HT_NONSEQ && $stable(haddr)));

    assert_status_code_R11: assert property (@(posedge hclk) disable iff (!hresetn)
        rsp_valid |-> (rsp_status != 2'b11));

endmodule

// File: tb/ahbm_master_bench.sv
module ahbm_master_bench;
    import ahbm_pkg::*;

    localparam int AW  = 32;
    localparam int DW  = 32;
    localparam int TMO = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          pipe_mode = 1'b0;
    logic          cmd_valid = 1'b0;
    logic          cmd_ready;
    logic          cmd_write = 1'b0;
    logic [AW-1:0] cmd_addr = '0;
    logic [DW-1:0] cmd_wdata = '0;
    logic [2:0]    cmd_size = 3'd2;
    logic          cmd_fmt = 1'b0;
    logic          rsp_valid;
    logic [1:0]    rsp_status;
    logic [DW-1:0] rsp_rdata;
    logic [AW-1:0] haddr;
    logic [1:0]    htrans;
    logic          hwrite;
    logic [2:0]    hsize;
    logic [DW-1:0] hwdata;
    logic [DW-1:0] hrdata = '0;
    logic          hready = 1'b1;
    logic          hresp = 1'b0;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    ahbm_master #(.ADDR_W(AW), .DATA_W(DW), .TIMEOUT_CYC(TMO)) u_ahbm_master (
        .hclk(clk), .hresetn(rst_n), .pipe_mode(pipe_mode),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_write(cmd_write),
        .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .cmd_size(cmd_size),
        .cmd_fmt(cmd_fmt), .rsp_valid(rsp_valid), .rsp_status(rsp_status),
        .rsp_rdata(rsp_rdata), .haddr(haddr), .htrans(htrans), .hwrite(hwrite),
        .hsize(hsize), .hwdata(hwdata), .hrdata(hrdata), .hready(hready),
        .hresp(hresp)
    );

    typedef struct packed {
        logic          wr;
        logic [31:0]   addr;
        logic [31:0]   wdata;
        logic [2:0]    size;
        logic          fmt;
        logic [2:0]    exp_hsize;
        logic [31:0]   exp_hwdata;
        logic [31:0]   rdata;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 32'h1000_0000, 32'hCAFE_F00D, 3'd2, 1'b1, 3'd2, 32'hCAFE_F00D, 32'h0},
        '{1'b1, 32'h1000_0006, 32'h0000_1234, 3'd1, 1'b1, 3'd1, 32'h1234_0000, 32'h0},
        '{1'b1, 32'h1000_0001, 32'hFFFF_FF5A, 3'd0, 1'b1, 3'd0, 32'h0000_5A00, 32'h0},
        '{1'b1, 32'h1000_0003, 32'hDEAD_BEEF, 3'd0, 1'b0, 3'd0, 32'hDEAD_BEEF, 32'h0},
        '{1'b1, 32'h1000_0007, 32'h0000_ABCD, 3'd1, 1'b1, 3'd1, 32'hABCD_0000, 32'h0},
        '{1'b1, 32'h2000_0000, 32'h1357_9BDF, 3'd3, 1'b1, 3'd2, 32'h1357_9BDF, 32'h0},
        '{1'b0, 32'h3000_0010, 32'h0,         3'd2, 1'b0, 3'd2, 32'h0,         32'h89AB_CDEF},
        '{1'b0, 32'h3000_0002, 32'h0,         3'd1, 1'b0, 3'd1, 32'h0,         32'h5555_AAAA}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic drive_cmd(input logic wr, input logic [31:0] a, input logic [31:0] d,
                             input logic [2:0] sz, input logic f);
        cmd_valid = 1'b1;
        cmd_write = wr;
        cmd_addr  = a;
        cmd_wdata = d;
        cmd_size  = sz;
        cmd_fmt   = f;
    endtask

    // non-pipelined single transfer, zero wait states; entered just after a negedge
    task automatic do_single(input vec_t v);
        drive_cmd(v.wr, v.addr, v.wdata, v.size, v.fmt);
        hrdata = v.rdata;
        chk("R2 ready when idle", 32'(cmd_ready), 32'd1);
        @(negedge clk);
        cmd_valid = 1'b0;
        chk("R2 address phase NONSEQ", 32'(htrans), 32'(HT_NONSEQ));
        chk("R2 haddr", haddr, v.addr);
        chk("R2 hwrite", 32'(hwrite), 32'(v.wr));
        chk("R10 hsize", 32'(hsize), 32'(v.exp_hsize));
        chk("R2 not ready in address phase", 32'(cmd_ready), 32'd0);
        @(negedge clk);
        chk("R2 IDLE during data phase", 32'(htrans), 32'(HT_IDLE));
        if (v.wr) begin
            if (v.fmt) chk("R8 lane placement", hwdata, v.exp_hwdata);
            else       chk("R9 raw write data", hwdata, v.exp_hwdata);
        end
        @(negedge clk);
        chk("R11 response pulse", 32'(rsp_valid), 32'd1);
        chk("R11 status OK", 32'(rsp_status), 32'(RSP_OK));
        chk("R11 response data", rsp_rdata, v.wr ? 32'h0 : v.rdata);
        @(negedge clk);
        chk("R11 single-cycle pulse", 32'(rsp_valid), 32'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual %h expected %h", 32'd0, 32'd1);
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        // reset state
        repeat (3) @(negedge clk);
        chk("R1 ready low in reset", 32'(cmd_ready), 32'd0);
        chk("R1 htrans IDLE in reset", 32'(htrans), 32'(HT_IDLE));
        chk("R1 no response in reset", 32'(rsp_valid), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // vector table, non-pipelined
        for (int i = 0; i < NV; i++) begin
            do_single(VECS[i]);
        end

        // R3: pipelined write then read
        pipe_mode = 1'b1;
        drive_cmd(1'b1, 32'h4000_0000, 32'h1111_2222, 3'd2, 1'b0);
        @(negedge clk);
        chk("R3 haddr first", haddr, 32'h4000_0000);
        chk("R3 ready during completing address phase", 32'(cmd_ready), 32'd1);
        drive_cmd(1'b0, 32'h4000_0004, 32'h0, 3'd2, 1'b0);
        @(negedge clk);
        cmd_valid = 1'b0;
        chk("R3 overlapped address", haddr, 32'h4000_0004);
        chk("R3 overlapped NONSEQ", 32'(htrans), 32'(HT_NONSEQ));
        chk("R3 overlapped write data", hwdata, 32'h1111_2222);
        hrdata = 32'h0BAD_CAFE;
        @(negedge clk);
        chk("R3 write response", 32'(rsp_valid), 32'd1);
        chk("R3 write status", 32'(rsp_status), 32'(RSP_OK));
        @(negedge clk);
        chk("R3 read response", 32'(rsp_valid), 32'd1);
        chk("R3 read data", rsp_rdata, 32'h0BAD_CAFE);

        // R4 and R3: read then write with two wait states
        @(negedge clk);
        drive_cmd(1'b0, 32'h5000_0008, 32'h0, 3'd2, 1'b0);
        @(negedge clk);
        drive_cmd(1'b1, 32'h5000_000C, 32'h7777_8888, 3'd2, 1'b0);
        @(negedge clk);
        cmd_valid = 1'b0;
        hready = 1'b0;
        hrdata = 32'h2468_ACE0;
        for (int k = 0; k < 2; k++) begin
            @(negedge clk);
            chk("R4 haddr held", haddr, 32'h5000_000C);
            chk("R4 htrans held", 32'(htrans), 32'(HT_NONSEQ));
            chk("R4 hwrite held", 32'(hwrite), 32'd1);
            chk("R4 hwdata held", hwdata, 32'h1111_2222);
            chk("R4 no response while waiting", 32'(rsp_valid), 32'd0);
            chk("R4 not ready while waiting", 32'(cmd_ready), 32'd0);
        end
        hready = 1'b1;
        @(negedge clk);
        chk("R3 read-then-write read data", rsp_rdata, 32'h2468_ACE0);
        chk("R3 read-then-write write data", hwdata, 32'h7777_8888);
        @(negedge clk);
        chk("R3 trailing write response", 32'(rsp_valid), 32'd1);

        // R5, R6: error with a queued address phase
        @(negedge clk);
        drive_cmd(1'b1, 32'h6000_0000, 32'hAAAA_0001, 3'd2, 1'b0);
        @(negedge clk);
        drive_cmd(1'b1, 32'h6000_0004, 32'hBBBB_0002, 3'd2, 1'b0);
        @(negedge clk);
        cmd_valid = 1'b0;
        hresp  = 1'b1;
        hready = 1'b0;
        @(negedge clk);
        chk("R5 IDLE in second error cycle", 32'(htrans), 32'(HT_IDLE));
        chk("R5 not ready while cancelled", 32'(cmd_ready), 32'd0);
        hready = 1'b1;
        @(negedge clk);
        hresp = 1'b0;
        chk("R5 error response", 32'(rsp_valid), 32'd1);
        chk("R5 error status", 32'(rsp_status), 32'(RSP_ERR));
        chk("R6 retry NONSEQ", 32'(htrans), 32'(HT_NONSEQ));
        chk("R6 retry address", haddr, 32'h6000_0004);
        @(negedge clk);
        chk("R6 retried write data", hwdata, 32'hBBBB_0002);
        @(negedge clk);
        chk("R6 retried response", 32'(rsp_valid), 32'd1);
        chk("R6 retried status", 32'(rsp_status), 32'(RSP_OK));

        // R7: timeout in non-pipelined mode
        @(negedge clk);
        pipe_mode = 1'b0;
        drive_cmd(1'b0, 32'h7000_0000, 32'h0, 3'd2, 1'b0);
        hrdata = 32'hFFFF_FFFF;
        @(negedge clk);
        cmd_valid = 1'b0;
        @(negedge clk);
        hready = 1'b0;
        for (int k = 0; k < TMO - 1; k++) begin
            @(negedge clk);
            chk("R7 no early timeout", 32'(rsp_valid), 32'd0);
        end
        @(negedge clk);
        chk("R7 timeout response", 32'(rsp_valid), 32'd1);
        chk("R7 timeout status", 32'(rsp_status), 32'(RSP_TMO));
        chk("R7 timeout data zero", rsp_rdata, 32'h0);
        chk("R7 ready after timeout", 32'(cmd_ready), 32'd1);
        hready = 1'b1;
        @(negedge clk);
        do_single(VECS[6]);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule